// File: doc/BRIEF.md
# Conversion and Power Mode Sequencer

This block is the device-side controller of a successive-approximation converter. A falling edge on the active-low start input `convst_ni` puts the track-and-hold into hold and runs a conversion of fixed length, timed in internal clock cycles. When the conversion ends, the block emits a one-cycle end strobe and samples the level of `convst_ni`. A high level keeps the device in normal mode. A low level sends it to power-down. In power-down, a rising edge of `convst_ni` starts a power-up interval of fixed length, and after it the device accepts a new start.

The block also watches the result-read port (`cs_ni`, `sclk_i`). A read that is abandoned early arms a software reset. A read is abandoned early when chip select returns high after the host has given at least `RST_MIN` and at most `RST_MAX` serial clock falling edges. The armed reset takes effect at the end of the next conversion. It emits a one-cycle pulse, forces normal mode and clears the error flag. Start edges that arrive while a conversion or a power-up is in progress are discarded and recorded in a sticky error flag. A power-on flag stays high until the first software reset executes. The SAR bit trials and the result data lie outside this block.

Top module: `adc_conv_seq`

## Requirements
- R1: A falling edge of `convst_ni` seen while the block is tracking (not converting, not in power-down or power-up) raises `hold_o` in the next cycle.
- R2: `hold_o` stays high for exactly `CONV_CYC` cycles. `eoc_o` is high for one cycle only, in the first cycle after `hold_o` falls.
- R3: At end of conversion, with no armed reset, `convst_ni` high keeps `pd_o` low, and `convst_ni` low raises `pd_o` in the cycle in which `eoc_o` is high.
- R4: In power-down, a rising edge of `convst_ni` starts power-up. `pd_o` stays high during `PWRUP_CYC` further cycles and then falls. A start edge is accepted from the first cycle in which `pd_o` is low.
- R5: A falling edge of `convst_ni` during a conversion or during power-up does not change the timing of `hold_o` or `pd_o`, and it sets `err_o`, which stays high until a software reset executes.
- R6: While `cs_ni` is low, falling edges of `sclk_i` are counted. The counter saturates. A rising edge of `cs_ni` arms a software reset only if the count is between `RST_MIN` and `RST_MAX` inclusive (defaults 2 and 8). A lower or higher count does not arm it.
- R7: An armed reset executes at the next end of conversion: `soft_rst_o` pulses in the same cycle as `eoc_o`. The block then returns to tracking whatever the level of `convst_ni` (so `pd_o` stays low), `err_o` is cleared, and the arm is consumed.
- R8: `por_o` is high from hardware reset until the first software reset executes. It falls in the cycle of that `soft_rst_o` pulse and stays low after it.
- R9: During and after hardware reset, `hold_o`, `eoc_o`, `pd_o`, `soft_rst_o` and `err_o` are low and `por_o` is high.
- R10: A falling edge of `convst_ni` in the cycle in which `eoc_o` is high starts the next conversion at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal conversion timebase |
| rst_ni | input | 1 | Asynchronous active-low reset |
| convst_ni | input | 1 | Active-low conversion start, synchronous to clk_i |
| cs_ni | input | 1 | Active-low chip select of the read port |
| sclk_i | input | 1 | Serial read clock, sampled by clk_i, idles high |
| hold_o | output | 1 | Track-and-hold in hold (conversion running) |
| eoc_o | output | 1 | One-cycle end-of-conversion strobe |
| pd_o | output | 1 | Powered down or powering up |
| soft_rst_o | output | 1 | One-cycle software reset pulse |
| err_o | output | 1 | Sticky flag for a discarded start edge |
| por_o | output | 1 | High until the first software reset |

## Verification
The assertions assume that `convst_ni`, `cs_ni` and `sclk_i` are already synchronous to `clk_i`, so each level change is seen as a single clean edge. They also assume that an abandoned read never ends in the same cycle as an end of conversion. The stimulus drives every input just after a rising clock edge, gives each serial clock level at least one full cycle, and finishes each read well away from an end of conversion. Each cycle, the outputs are compared with a behavioural model. That model tracks its own countdown integers, mode and arm flag.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_TRACK = 2'd0,
    ST_CONV  = 2'd1,
    ST_PD    = 2'd2,
    ST_PWRUP = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_seq_edge.sv
module adc_seq_edge #(
  parameter int          W       = 3,
  parameter logic [W-1:0] IDLE_V = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= IDLE_V[g];
      else         q <= d_i[g];
    end
    assign q_o[g]    = q;
    assign rise_o[g] = d_i[g] & ~q;
    assign fall_o[g] = ~d_i[g] & q;
  end
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int MAX_V = 10000,
  localparam int TW   = $clog2(MAX_V + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  input  logic          en_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= val_i;
    else if (en_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TW'(MAX_V)); // R2
endmodule

// File: rtl/adc_seq_readmon.sv
module adc_seq_readmon #(
  parameter int RST_MIN = 2,
  parameter int RST_MAX = 8,
  localparam int CW     = $clog2(RST_MAX + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic cs_q_i,
  input  logic cs_rise_i,
  input  logic sclk_fall_i,
  output logic arm_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (cs_ni)                      cnt_q <= '0;
    else if (sclk_fall_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  assign arm_o = cs_rise_i && (cnt_q >= CW'(RST_MIN)) && (cnt_q <= CW'(RST_MAX));

  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q_i |-> cnt_q == '0); // R6
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYC  = 65,
  parameter int PWRUP_CYC = 10000,
  parameter int RST_MIN   = 2,
  parameter int RST_MAX   = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic convst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic hold_o,
  output logic eoc_o,
  output logic pd_o,
  output logic soft_rst_o,
  output logic err_o,
  output logic por_o
);
  localparam int MAX_CYC = (CONV_CYC > PWRUP_CYC) ? CONV_CYC : PWRUP_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] CONV_LD  = TW'(CONV_CYC - 1);
  localparam logic [TW-1:0] PWRUP_LD = TW'(PWRUP_CYC - 1);

  // bit 0 convst, bit 1 cs, bit 2 sclk; all idle high
  logic [2:0] in_q, in_rise, in_fall;
  adc_seq_edge #(.W(3), .IDLE_V(3'b111)) u_edge (
    .clk_i, .rst_ni,
    .d_i({sclk_i, cs_ni, convst_ni}),
    .q_o(in_q), .rise_o(in_rise), .fall_o(in_fall)
  );

  logic arm_evt;
  adc_seq_readmon #(.RST_MIN(RST_MIN), .RST_MAX(RST_MAX)) u_rmon (
    .clk_i, .rst_ni, .cs_ni,
    .cs_q_i(in_q[1]), .cs_rise_i(in_rise[1]), .sclk_fall_i(in_fall[2]),
    .arm_o(arm_evt)
  );

  seq_state_e state_q;
  logic tmr_load, tmr_zero, tmr_en;
  logic [TW-1:0] tmr_val;

  assign tmr_load = (state_q == ST_TRACK && in_fall[0]) || (state_q == ST_PD && in_rise[0]);
  assign tmr_val  = (state_q == ST_PD) ? PWRUP_LD : CONV_LD;
  assign tmr_en   = (state_q == ST_CONV) || (state_q == ST_PWRUP);

  adc_seq_timer #(.MAX_V(MAX_CYC)) u_tmr (
    .clk_i, .rst_ni,
    .load_i(tmr_load), .val_i(tmr_val), .en_i(tmr_en), .zero_o(tmr_zero)
  );

  logic armed_q, conv_end, fire, bad_start;
  assign conv_end  = (state_q == ST_CONV) && tmr_zero;
  assign fire      = conv_end && armed_q;
  assign bad_start = tmr_en && in_fall[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_TRACK;
      eoc_o      <= 1'b0;
      soft_rst_o <= 1'b0;
      err_o      <= 1'b0;
      por_o      <= 1'b1;
      armed_q    <= 1'b0;
    end else begin
      eoc_o      <= conv_end;
      soft_rst_o <= fire;
      armed_q    <= (armed_q & ~fire) | arm_evt;
      if (fire) begin
        err_o <= 1'b0;
        por_o <= 1'b0;
      end else if (bad_start) begin
        err_o <= 1'b1;
      end
      unique case (state_q)
        ST_TRACK: if (in_fall[0]) state_q <= ST_CONV;
        ST_CONV:  if (tmr_zero)
                    state_q <= (armed_q || convst_ni) ? ST_TRACK : ST_PD;
        ST_PD:    if (in_rise[0]) state_q <= ST_PWRUP;
        ST_PWRUP: if (tmr_zero) state_q <= ST_TRACK;
        default:  state_q <= ST_TRACK;
      endcase
    end
  end

  assign hold_o = (state_q == ST_CONV);
  assign pd_o   = (state_q == ST_PD) || (state_q == ST_PWRUP);

  AST_EOC_AFTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> eoc_o); // R2
  AST_EOC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o); // R2
  AST_PD_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_o) |-> eoc_o && !$past(convst_ni)); // R3
  AST_SRST_AT_EOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> eoc_o && !pd_o && !err_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> soft_rst_o); // R5
  AST_POR_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_o |=> !por_o); // R8
  AST_NO_HOLD_IN_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hold_o && pd_o)); // R4
endmodule

// File: tb/sim_adc_conv_seq.sv
`timescale 1ns/1ps
module sim_adc_conv_seq;
  localparam int CONV  = 6;
  localparam int PWRUP = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic convst_n = 1'b1, cs_n = 1'b1, sclk = 1'b1;
  logic hold, eoc, pd, srst, err, por;
  int   total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  adc_conv_seq #(.CONV_CYC(CONV), .PWRUP_CYC(PWRUP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .convst_ni(convst_n), .cs_ni(cs_n), .sclk_i(sclk),
    .hold_o(hold), .eoc_o(eoc), .pd_o(pd), .soft_rst_o(srst), .err_o(err), .por_o(por)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: got %0d want %0d", req, cyc, act, exp);
    end
  endtask

  // behavioural reference: mode 0 track, 1 converting, 2 powered down, 3 powering up
  int mode = 0, left = 0, rd_cnt = 0;
  bit armed = 0, m_err = 0, m_por = 1, m_eoc = 0, m_srst = 0;
  bit p_cv = 1, p_cs = 1, p_sk = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0; left = 0; rd_cnt = 0; armed = 0; m_err = 0; m_por = 1;
      m_eoc = 0; m_srst = 0; p_cv = 1; p_cs = 1; p_sk = 1;
    end else begin
      bit fall_cv, rise_cv;
      fall_cv = p_cv && !convst_n;
      rise_cv = !p_cv && convst_n;
      m_eoc = 0; m_srst = 0;
      case (mode)
        0: if (fall_cv) begin mode = 1; left = CONV; end
        1: begin
             if (fall_cv) m_err = 1;
             left--;
             if (left == 0) begin
               m_eoc = 1;
               if (armed) begin
                 m_srst = 1; armed = 0; m_err = 0; m_por = 0; mode = 0;
               end else mode = convst_n ? 0 : 2;
             end
           end
        2: if (rise_cv) begin mode = 3; left = PWRUP; end
        default: begin
             if (fall_cv) m_err = 1;
             left--;
             if (left == 0) mode = 0;
           end
      endcase
      if (!p_cs && cs_n && rd_cnt >= 2 && rd_cnt <= 8) armed = 1;
      if (cs_n) rd_cnt = 0;
      else if (p_sk && !sclk && rd_cnt < 15) rd_cnt++;
      p_cv = convst_n; p_cs = cs_n; p_sk = sclk;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R1/R2 hold", hold, mode == 1);
      chk("R2/R3 eoc", eoc, m_eoc);
      chk("R3/R4 pd", pd, mode >= 2);
      chk("R5 err", err, m_err);
      chk("R6/R7 soft_rst", srst, m_srst);
      chk("R8 por", por, m_por);
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic start(input int low_cyc);
    convst_n = 1'b0; tick(low_cyc); convst_n = 1'b1;
  endtask

  task automatic rd(input int falls);
    cs_n = 1'b0; tick(2);
    for (int i = 0; i < falls; i++) begin
      sclk = 1'b0; tick(1); sclk = 1'b1; tick(1);
    end
    cs_n = 1'b1; tick(2);
  endtask

  task automatic wait_eoc();
    while (!eoc) tick(1);
  endtask

  initial begin : watchdog
    while (cyc < 20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    // R9 reset state
    chk("R9 hold", hold, 0); chk("R9 eoc", eoc, 0); chk("R9 pd", pd, 0);
    chk("R9 srst", srst, 0); chk("R9 err", err, 0); chk("R9 por", por, 1);
    rst_n = 1'b1; tick(3);

    // R1 R2 normal conversion
    start(2); tick(1);
    chk("R1 hold after start", hold, 1);
    wait_eoc();
    chk("R2 hold low at eoc", hold, 0);
    // R10 back-to-back start in eoc cycle
    start(1);
    chk("R10 immediate restart", hold, 1);
    wait_eoc(); tick(3);

    // R5 extra start during conversion
    start(1); tick(2); start(1);
    wait_eoc(); tick(1);
    chk("R5 err sticky", err, 1);

    // R3 R4 power-down entry and power-up with stray start
    convst_n = 1'b0; wait_eoc(); tick(1);
    chk("R3 pd entered", pd, 1);
    tick(4); convst_n = 1'b1; tick(5);
    start(1);
    tick(PWRUP);
    chk("R4 pd released", pd, 0);
    start(1); tick(1);
    chk("R4 start accepted after power-up", hold, 1);
    wait_eoc(); tick(3);

    // R6 counts outside range do not arm
    rd(1); rd(9); rd(12);
    start(1); wait_eoc(); tick(1);
    chk("R6 no arm outside range", srst, 0);
    chk("R8 por still high", por, 1);
    tick(2);

    // R6 R7 arm with 5, reset fires at next eoc, clears err
    rd(5);
    start(1); tick(1); start(1);
    wait_eoc();
    chk("R7 soft reset with eoc", srst, 1);
    tick(1);
    chk("R7 err cleared", err, 0);
    chk("R8 por low", por, 0);
    tick(3);

    // R7 boundary 2 with convst low at eoc: reset forces track
    rd(2);
    convst_n = 1'b0; wait_eoc(); tick(1);
    chk("R7 forced track", pd, 0);
    convst_n = 1'b1; tick(3);
    // boundary 8 arms
    rd(8);
    start(1); wait_eoc();
    chk("R6 arm at upper bound", srst, 1);
    tick(3);
    // arm consumed
    start(1); wait_eoc();
    chk("R7 arm consumed", srst, 0);
    tick(5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule